// File: doc/BRIEF.md
# Cipher Host Controller

This block is the register-side front end of a 128-bit block-cipher accelerator. A host loads one data block as four 32-bit writes to a single input register, waits for the completion flag, then pulls the result as four 32-bit reads from a single output register. The block counts the words, starts a computation whose length depends on the selected operation, raises a completion flag, and flags accesses that break the four-in, four-out order. Both kinds of event can raise maskable interrupts. Two request lines let a DMA engine feed the input phase and drain the output phase.

The cipher itself is replaced by a stand-in that waits the mode's cycle count and then produces a simple keyed result. The stand-in lets the sequencing, flags and access rules be checked on their own. Key derivation replaces the key with its bitwise inverse. Encrypt and decrypt produce the data block XOR the key. Derive-then-decrypt produces the data block XOR the derived key.

Registers sit at word addresses:
- 0: control
- 1: status
- 2: input
- 3: output
- 4 to 7: key, most significant word first
- 8 to 11: IV, most significant word first

Control bits:
- bit 0: enable
- bits 2:1: operation (0 encrypt, 1 decrypt, 2 derive key only, 3 derive then decrypt)
- bits 4:3: chaining
- bits 6:5: data type
- bit 7: write 1 to clear completion
- bit 8: write 1 to clear both errors
- bit 9: completion interrupt enable
- bit 10: error interrupt enable
- bit 11: input DMA enable
- bit 12: output DMA enable

Status bits:
- bit 0: completion
- bit 1: read error
- bit 2: write error
- bit 3: busy

Top module: `cipher_host_ctrl`

## Requirements
- R1: Four accepted writes to address 2 form one block, the first word becoming bits 127:96. In encrypt or decrypt mode, the four reads from address 3 return that block XOR the key, most significant word first.
- R2: The completion flag rises exactly N clock edges after the edge that accepts the fourth input word. N is 214 for encrypt, 214 for decrypt, 288 for derive then decrypt. For derive-only, N is 80 and is counted from the edge that writes the enable bit.
- R3: The completion flag (status bit 0) stays set until a control write with bit 7 set clears it; bits 7 and 8 read back as 0.
- R4: While enabled, a write to address 2 sets the write-error flag (status bit 2) in three cases: during a computation, while result words remain unread, or in derive-only mode. While disabled, such a write has no effect.
- R5: While enabled, a read of address 3 sets the read-error flag (status bit 1) and returns 0 unless result words remain unread. A control write with bit 8 set clears both error flags.
- R6: irq_done equals completion AND control bit 9; irq_err equals control bit 10 AND (read error OR write error).
- R7: While the block is enabled, control writes leave the operation, chaining and data-type fields unchanged.
- R8: Key writes are ignored while enabled. Key reads return 0 while enabled and the stored key while disabled.
- R9: IV reads return 0 while enabled and the written value while disabled.
- R10: Both derivation modes replace the key with its bitwise inverse when the computation ends. Derive-then-decrypt returns the block XOR the derived key.
- R11: dma_in_req is high only while enabled, input DMA is enabled, the block is collecting input, and the mode is not derive-only. dma_out_req is high only while enabled, output DMA is enabled, completion is set and result words remain unread.
- R12: Clearing the enable bit aborts any computation and resets both word counters.
- R13: After reset all registers, flags, interrupts and requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 3) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Access-error interrupt |
| dma_in_req | output | 1 | Request for the next input word |
| dma_out_req | output | 1 | Request to read the next result word |

## Verification
The assertions take for granted that the host uses one bus port: at most one of wr_en and rd_en is high in a cycle, and addr is stable while either is high. They also assume reset is held for at least one edge before traffic starts. The stimulus drives every access on the falling edge, one at a time. Each access is held for exactly one rising edge and then returned to idle. Bus inputs are only touched after reset has been released.

// File: rtl/cipher_host_ctrl.sv
module cipher_host_ctrl #(
  parameter int LAT_ENC = 214,
  parameter int LAT_DEC = 214,
  parameter int LAT_KDV = 80,
  parameter int LAT_KDD = 288
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_done,
  output logic        irq_err,
  output logic        dma_in_req,
  output logic        dma_out_req
);
  localparam int LMAX = (LAT_KDD > LAT_ENC) ? ((LAT_KDD > LAT_DEC) ? LAT_KDD : LAT_DEC)
                                            : ((LAT_ENC > LAT_DEC) ? LAT_ENC : LAT_DEC);
  localparam int CW = $clog2(LMAX + 1);
  localparam logic [1:0] OP_KDV = 2'd2;
  localparam logic [1:0] OP_KDD = 2'd3;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_OUT = 2'd2} st_t;

  st_t          st_q;
  logic         en_q, done_ie_q, err_ie_q, dmai_en_q, dmao_en_q;
  logic [1:0]   op_q, chain_q, dtype_q;
  logic         done_q, rderr_q, wrerr_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]   in_cnt, out_cnt;
  logic [127:0] din_q, dout_q, key_q, iv_q;

  function automatic logic [CW-1:0] lat_of(input logic [1:0] m);
    case (m)
      2'd0:    return CW'(LAT_ENC);
      2'd1:    return CW'(LAT_DEC);
      2'd2:    return CW'(LAT_KDV);
      default: return CW'(LAT_KDD);
    endcase
  endfunction

  wire ctrl_wr   = wr_en && addr == 4'd0;
  wire din_wr    = wr_en && addr == 4'd2;
  wire dout_rd   = rd_en && addr == 4'd3;
  wire key_wr    = wr_en && addr[3:2] == 2'b01;
  wire iv_wr     = wr_en && addr[3:2] == 2'b10;
  wire done_clr  = ctrl_wr && wdata[7];
  wire err_clr_w = ctrl_wr && wdata[8];
  wire stop      = ctrl_wr && !wdata[0];
  wire start_kd  = ctrl_wr && !en_q && wdata[0] && wdata[2:1] == OP_KDV;
  wire din_ok    = en_q && st_q == ST_IDLE && op_q != OP_KDV;
  wire dout_ok   = en_q && st_q == ST_OUT;
  wire din_bad   = din_wr && en_q && !din_ok;
  wire dout_bad  = dout_rd && en_q && !dout_ok;
  wire finish    = st_q == ST_BUSY && cnt_q == CW'(1);
  wire derive    = op_q == OP_KDV || op_q == OP_KDD;

  assign irq_done    = done_q && done_ie_q;
  assign irq_err     = err_ie_q && (rderr_q || wrerr_q);
  assign dma_in_req  = dmai_en_q && din_ok;
  assign dma_out_req = dmao_en_q && dout_ok && done_q && op_q != OP_KDV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; done_ie_q <= 1'b0; err_ie_q <= 1'b0;
      dmai_en_q <= 1'b0; dmao_en_q <= 1'b0;
      op_q <= '0; chain_q <= '0; dtype_q <= '0;
      key_q <= '0; iv_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q      <= wdata[0];
        done_ie_q <= wdata[9];
        err_ie_q  <= wdata[10];
        dmai_en_q <= wdata[11];
        dmao_en_q <= wdata[12];
        if (!en_q) begin
          op_q    <= wdata[2:1];
          chain_q <= wdata[4:3];
          dtype_q <= wdata[6:5];
        end
      end
      if (key_wr && !en_q) key_q[{~addr[1:0], 5'b0} +: 32] <= wdata;
      if (iv_wr) iv_q[{~addr[1:0], 5'b0} +: 32] <= wdata;
      if (finish && derive) key_q <= ~key_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; rderr_q <= 1'b0; wrerr_q <= 1'b0;
    end else begin
      if (finish) done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (din_bad) wrerr_q <= 1'b1;
      else if (err_clr_w) wrerr_q <= 1'b0;
      if (dout_bad) rderr_q <= 1'b1;
      else if (err_clr_w) rderr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; in_cnt <= '0; out_cnt <= '0;
      din_q <= '0; dout_q <= '0;
    end else if (stop) begin
      st_q <= ST_IDLE; in_cnt <= '0; out_cnt <= '0;
    end else if (start_kd) begin
      st_q  <= ST_BUSY;
      cnt_q <= CW'(LAT_KDV);
    end else begin
      case (st_q)
        ST_IDLE: if (din_wr && din_ok) begin
          din_q[{~in_cnt, 5'b0} +: 32] <= wdata;
          in_cnt <= in_cnt + 2'd1;
          if (in_cnt == 2'd3) begin
            st_q  <= ST_BUSY;
            cnt_q <= lat_of(op_q);
          end
        end
        ST_BUSY: if (finish) begin
          st_q    <= (op_q == OP_KDV) ? ST_IDLE : ST_OUT;
          out_cnt <= '0;
          dout_q  <= din_q ^ (op_q == OP_KDD ? ~key_q : key_q);
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        ST_OUT: if (dout_rd) begin
          out_cnt <= out_cnt + 2'd1;
          if (out_cnt == 2'd3) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      4'd0: rdata = {19'b0, dmao_en_q, dmai_en_q, err_ie_q, done_ie_q, 2'b00,
                     dtype_q, chain_q, op_q, en_q};
      4'd1: rdata = {28'b0, st_q == ST_BUSY, wrerr_q, rderr_q, done_q};
      4'd3: if (dout_ok) rdata = dout_q[{~out_cnt, 5'b0} +: 32];
      4'd4, 4'd5, 4'd6, 4'd7: if (!en_q) rdata = key_q[{~addr[1:0], 5'b0} +: 32];
      4'd8, 4'd9, 4'd10, 4'd11: if (!en_q) rdata = iv_q[{~addr[1:0], 5'b0} +: 32];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cipher_host_ctrl_chk.sv
module cipher_host_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   op,
  input logic [1:0]   st,
  input logic [1:0]   in_cnt,
  input logic [1:0]   out_cnt,
  input logic         done,
  input logic         wrerr,
  input logic         err_clr,
  input logic [127:0] key,
  input logic         dma_in,
  input logic         dma_out
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_BUSY = 2'd1;

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (st == S_IDLE && in_cnt == 2'd0 && out_cnt == 2'd0)); // R12
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st) == S_BUSY); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(op)); // R7
  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(st) != S_BUSY) |-> $stable(key)); // R8
  AST_KDV_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2) |-> (!dma_in && !dma_out)); // R11
  AST_WRERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrerr) && !$past(err_clr)) |-> wrerr); // R4
endmodule

bind cipher_host_ctrl cipher_host_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_q), .op(op_q), .st(st_q),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .done(done_q), .wrerr(wrerr_q),
  .err_clr(err_clr_w), .key(key_q), .dma_in(dma_in_req), .dma_out(dma_out_req)
);

// File: tb/cipher_host_ctrl_tb_top.sv
module cipher_host_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] EN = 32'h1, CLR_DONE = 32'h80, CLR_ERR = 32'h100,
    IE_DONE = 32'h200, IE_ERR = 32'h400, DMA_IN = 32'h800, DMA_OUT = 32'h1000;
  localparam logic [257:0] VEC [0:3] = '{
    {2'd0, 128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff},
    {2'd1, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734},
    {2'd3, 128'hdeadbeef0badf00dcafebabe12345678, 128'hffffffff00000000a5a5a5a55a5a5a5a},
    {2'd0, 128'h80000000000000000000000000000001, 128'h0123456789abcdeffedcba9876543210}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq_done, irq_err, dma_in_req, dma_out_req;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  cipher_host_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_done(irq_done), .irq_err(irq_err),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req));

  function automatic int lat_of(input logic [1:0] op);
    case (op) 2'd0: return 214; 2'd1: return 214; 2'd2: return 80; default: return 288; endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic strobe, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = strobe; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr_key(input logic [127:0] k);
    for (int j = 0; j < 4; j++) wr(4'(4 + j), k[127 - 32*j -: 32]);
  endtask

  task automatic wr_blk(input logic [127:0] b);
    for (int j = 0; j < 4; j++) wr(4'd2, b[127 - 32*j -: 32]);
  endtask

  task automatic rd_blk(output logic [127:0] b);
    logic [31:0] w;
    b = '0;
    for (int j = 0; j < 4; j++) begin rd(4'd3, 1'b1, w); b = {b[95:0], w}; end
  endtask

  task automatic rd_key(output logic [127:0] k);
    logic [31:0] w;
    k = '0;
    for (int j = 0; j < 4; j++) begin rd(4'(4 + j), 1'b0, w); k = {k[95:0], w}; end
  endtask

  task automatic wait_done(output int n);
    n = 0; addr = 4'd1; #1;
    while (!rdata[0] && n < 2000) begin @(negedge clk); n++; addr = 4'd1; #1; end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] w;
    logic [127:0] b, k;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    rd(4'd0, 1'b0, w); chk("R13 ctrl", 128'(w), 0);
    rd(4'd1, 1'b0, w); chk("R13 status", 128'(w), 0);
    chk("R13 outputs", {irq_done, irq_err, dma_in_req, dma_out_req}, 0);

    for (int i = 0; i < 4; i++) begin
      logic [1:0] op;
      logic [127:0] key, dat, exp;
      op = VEC[i][257:256]; key = VEC[i][255:128]; dat = VEC[i][127:0];
      exp = dat ^ ((op == 2'd3) ? ~key : key);
      wr(4'd0, 0);
      wr_key(key);
      wr(4'd0, EN | 32'(op) << 1 | IE_DONE | DMA_IN | DMA_OUT);
      chk("R11 dma_in collecting", 128'(dma_in_req), 1);
      wr_blk(dat);
      chk("R11 dma_in busy", 128'(dma_in_req), 0);
      wait_done(n);
      chk("R2 latency", 128'(n), 128'(lat_of(op)));
      chk("R6 irq_done", 128'(irq_done), 1);
      chk("R11 dma_out", 128'(dma_out_req), 1);
      rd_blk(b);
      chk("R1 result", b, exp);
      chk("R11 dma_out drained", 128'(dma_out_req), 0);
      wr(4'd0, EN | 32'(op) << 1 | IE_DONE | CLR_DONE);
      rd(4'd1, 1'b0, w); chk("R3 done cleared", 128'(w[0]), 0);
      chk("R6 irq_done cleared", 128'(irq_done), 0);
      rd(4'd0, 1'b0, w); chk("R3 clear bits read 0", 128'(w[8:7]), 0);
      if (op == 2'd3) begin
        wr(4'd0, 0);
        rd_key(k); chk("R10 derived key", k, ~key);
      end
    end

    // R7 config frozen
    wr(4'd0, 0);
    wr_key(128'h11111111222222223333333344444444);
    wr(4'd0, EN);
    wr(4'd0, EN | 32'h1e);
    rd(4'd0, 1'b0, w); chk("R7 fields frozen", 128'(w[6:1]), 0);
    // R8 key frozen and hidden
    wr(4'd4, 32'hffffffff);
    rd(4'd4, 1'b0, w); chk("R8 key hidden", 128'(w), 0);
    wr(4'd0, 0);
    rd(4'd4, 1'b0, w); chk("R8 key unchanged", 128'(w), 128'h11111111);
    // R9 IV
    wr(4'd9, 32'hcafe1234);
    rd(4'd9, 1'b0, w); chk("R9 iv disabled", 128'(w), 128'hcafe1234);
    wr(4'd0, EN);
    rd(4'd9, 1'b0, w); chk("R9 iv enabled", 128'(w), 0);

    // R4 R5 errors
    wr(4'd0, EN | IE_ERR);
    rd(4'd3, 1'b1, w);
    chk("R5 early read data", 128'(w), 0);
    rd(4'd1, 1'b0, w); chk("R5 rderr early", 128'(w[2:1]), 1);
    chk("R6 irq_err", 128'(irq_err), 1);
    wr(4'd0, EN | IE_ERR | CLR_ERR);
    rd(4'd1, 1'b0, w); chk("R5 err clear", 128'(w[2:1]), 0);
    chk("R6 irq_err clear", 128'(irq_err), 0);
    wr_blk(128'h0);
    wr(4'd2, 32'h5);
    rd(4'd1, 1'b0, w); chk("R4 wrerr busy", 128'(w[3:1]), 128'b110);
    wr(4'd0, EN | IE_ERR | CLR_ERR);
    wait_done(n);
    wr(4'd2, 32'h6);
    rd(4'd1, 1'b0, w); chk("R4 wrerr unread", 128'(w[2:0]), 128'b101);
    rd_blk(b); chk("R1 result after err", b, 128'h11111111222222223333333344444444);
    rd(4'd3, 1'b1, w);
    rd(4'd1, 1'b0, w); chk("R5 rderr extra read", 128'(w[2:1]), 128'b11);
    wr(4'd0, 0 | CLR_ERR | CLR_DONE);
    wr(4'd2, 32'h7);
    rd(4'd1, 1'b0, w); chk("R4 disabled write ignored", 128'(w), 0);

    // R10 key derivation only
    wr_key(128'h0f0f0f0f00000000ffffffff12121212);
    wr(4'd0, EN | (32'd2 << 1) | DMA_IN | DMA_OUT);
    chk("R11 no dma in kdv", 128'({dma_in_req, dma_out_req}), 0);
    wait_done(n);
    chk("R2 kdv latency", 128'(n), 80);
    chk("R11 no dma in kdv done", 128'({dma_in_req, dma_out_req}), 0);
    wr(4'd2, 32'h1);
    rd(4'd1, 1'b0, w); chk("R4 wrerr kdv", 128'(w[2]), 1);
    rd_key(k); chk("R8 key hidden kdv", k, 0);
    wr(4'd0, CLR_ERR | CLR_DONE);
    rd_key(k); chk("R10 derived key kdv", k, ~128'h0f0f0f0f00000000ffffffff12121212);

    // R12 abort
    wr_key(128'h0);
    wr(4'd0, EN);
    wr(4'd2, 32'haaaaaaaa); wr(4'd2, 32'hbbbbbbbb);
    wr(4'd0, 0);
    wr(4'd0, EN);
    wr_blk(128'h00000001000000020000000300000004);
    wait_done(n);
    chk("R12 counter reset latency", 128'(n), 214);
    rd_blk(b); chk("R12 block after abort", b, 128'h00000001000000020000000300000004);
    wr(4'd0, EN | CLR_DONE);
    wr_blk(128'h5);
    repeat (50) @(negedge clk);
    wr(4'd0, 0);
    wr(4'd0, EN);
    repeat (300) @(negedge clk);
    rd(4'd1, 1'b0, w); chk("R12 aborted no done", 128'(w), 0);
    chk("R11 dma_in idle after abort", 128'(dma_in_req), 0);
    summary();
  end
endmodule